// File: doc/BRIEF.md
# In-Order DRAM Command Arbiter

This block sits between a set of per-bank state machines and the single DRAM command bus. In each cycle every bank may offer one command (activate, precharge, read or write) together with the ID of the request it serves. The arbiter forwards at most one of these commands to the command bus. It returns a one-hot grant to the bank whose command went out.

Requests enter through an accept port. Their IDs are kept in a first-in first-out order queue. Row commands (activate, precharge) may go out for any request, so banks can open and close rows in parallel. A column command (read, write) goes out only when it serves the oldest outstanding request. When it does, that request leaves the queue. Data therefore comes back in the order the requests were accepted.

The arbiter decides within the cycle: the issued command, its bank, its ID and the grant are combinational from the bank inputs and the head of the queue. Only the order queue holds state. Timing checks are done in the bank machines, upstream of this block.

Top module: `inorder_cmd_arb`

## Requirements
- R1: After synchronous reset the order queue is empty, `acc_ready` is 1, and no column command can be issued until an ID has been accepted.
- R2: Each ID accepted (`acc_valid` and `acc_ready` high at a clock edge) joins the tail of the order queue, and IDs leave it strictly in acceptance order.
- R3: Command codes on `bank_cmd` are 3-bit fields, bank b at bits [3b+2:3b]: 0 none, 1 activate, 2 precharge, 3 read, 4 write. If any bank offers an activate or precharge, the lowest-numbered such bank is issued, and no column command is issued that cycle.
- R4: With no row command offered, the lowest-numbered bank offering a read or write whose ID (bank b at `bank_id` bits [ID_W*b+ID_W-1:ID_W*b]) equals the queue head is issued, and the head is removed at that clock edge.
- R5: At most one command is issued per cycle. `grant` is one-hot at bit `iss_bank` while `iss_valid` is high, and `iss_cmd`/`iss_id` carry that bank's code and ID.
- R6: If no candidate qualifies, including a column command for a non-head ID or any column command while the queue is empty, `iss_valid` is 0, `iss_cmd` is 0 and `grant` is all zero.
- R7: An accept and a head removal in the same cycle both take effect: the occupancy is unchanged and the new ID joins behind the remaining ones.
- R8: When the queue holds DEPTH IDs, `acc_ready` is 0 and an offered ID is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A request is offered for acceptance |
| acc_id | input | ID_W | ID of the offered request |
| acc_ready | output | 1 | Order queue can take an ID |
| bank_cmd | input | 3*NBANK | Command code per bank |
| bank_id | input | ID_W*NBANK | Request ID per bank |
| iss_valid | output | 1 | A command is issued this cycle |
| iss_cmd | output | 3 | Issued command code |
| iss_bank | output | BANK_W | Issuing bank index |
| iss_id | output | ID_W | Request ID of the issued command |
| grant | output | NBANK | One-hot grant to the issuing bank |

## Verification
Two functions can fall in the same cycle: accepting a new ID and retiring the head through a column issue. The bench provokes this by offering an ID in the same cycle that the bank holding the head ID offers a read. It judges the result in later cycles: the next head must be the older remaining ID, and the freshly pushed ID must come out after it. A second overlap is a row command in the same cycle as a head-matching column command. The row command must win and the head must stay in place, which the bench confirms when the column command is issued one cycle later.

// File: rtl/inorder_cmd_arb_pkg.sv
package inorder_cmd_arb_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_PRE  = 3'd2,
        CMD_RD   = 3'd3,
        CMD_WR   = 3'd4
    } cmd_t;

    localparam int CMD_W = 3;

    function automatic logic is_row_cmd(input logic [CMD_W-1:0] c);
        return (c == CMD_ACT) || (c == CMD_PRE);
    endfunction

    function automatic logic is_col_cmd(input logic [CMD_W-1:0] c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/order_queue.sv
module order_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic [OCC_W-1:0] occ
);
    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (occ == '0);
    assign full  = (occ == OCC_W'(DEPTH));
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= nxt(wr_ptr);
            end
            if (pop)
                rd_ptr <= nxt(rd_ptr);
            if (push && !pop)
                occ <= occ + 1'b1;
            else if (pop && !push)
                occ <= occ - 1'b1;
        end
    end
endmodule

// File: rtl/fixed_prio_pick.sv
module fixed_prio_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                any    = 1'b1;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/inorder_cmd_arb.sv
module inorder_cmd_arb
    import inorder_cmd_arb_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int ID_W  = 4,
    parameter int DEPTH = 4,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   acc_valid,
    input  logic [ID_W-1:0]        acc_id,
    output logic                   acc_ready,
    input  logic [CMD_W*NBANK-1:0] bank_cmd,
    input  logic [ID_W*NBANK-1:0]  bank_id,
    output logic                   iss_valid,
    output logic [CMD_W-1:0]       iss_cmd,
    output logic [BANK_W-1:0]      iss_bank,
    output logic [ID_W-1:0]        iss_id,
    output logic [NBANK-1:0]       grant
);
    logic [ID_W-1:0]   head_id;
    logic              q_empty, q_full, q_push, q_pop;
    logic [OCC_W-1:0]  occ;
    logic [NBANK-1:0]  row_req, col_req, row_gnt, col_gnt;
    logic              row_any, col_any;
    logic [BANK_W-1:0] row_idx, col_idx;

    for (genvar b = 0; b < NBANK; b++) begin : g_cand
        logic [CMD_W-1:0] c;
        logic [ID_W-1:0]  id;
        assign c          = bank_cmd[CMD_W*b +: CMD_W];
        assign id         = bank_id[ID_W*b +: ID_W];
        assign row_req[b] = is_row_cmd(c);
        assign col_req[b] = is_col_cmd(c) && !q_empty && (id == head_id);
    end

    fixed_prio_pick #(.N(NBANK)) u_row_pick (
        .req(row_req), .gnt(row_gnt), .any(row_any), .idx(row_idx)
    );

    fixed_prio_pick #(.N(NBANK)) u_col_pick (
        .req(col_req), .gnt(col_gnt), .any(col_any), .idx(col_idx)
    );

    assign iss_valid = row_any || col_any;
    assign iss_bank  = row_any ? row_idx : col_idx;
    assign grant     = row_any ? row_gnt : col_gnt;
    assign iss_cmd   = iss_valid ? bank_cmd[CMD_W*iss_bank +: CMD_W] : CMD_W'(CMD_NONE);
    assign iss_id    = iss_valid ? bank_id[ID_W*iss_bank +: ID_W] : '0;

    assign acc_ready = !q_full;
    assign q_push    = acc_valid && !q_full;
    assign q_pop     = !row_any && col_any;

    order_queue #(.DEPTH(DEPTH), .W(ID_W)) u_queue (
        .clk(clk), .rst(rst),
        .push(q_push), .push_data(acc_id),
        .pop(q_pop), .head(head_id),
        .empty(q_empty), .full(q_full), .occ(occ)
    );
endmodule

// File: rtl/inorder_cmd_arb_chk.sv
module inorder_cmd_arb_chk
    import inorder_cmd_arb_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int ID_W  = 4,
    parameter int DEPTH = 4,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int OCC_W  = $clog2(DEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   acc_valid,
    input logic                   acc_ready,
    input logic [CMD_W*NBANK-1:0] bank_cmd,
    input logic                   iss_valid,
    input logic [CMD_W-1:0]       iss_cmd,
    input logic [BANK_W-1:0]      iss_bank,
    input logic [NBANK-1:0]       grant,
    input logic [OCC_W-1:0]       occ
);
    logic any_row;
    always_comb begin
        any_row = 1'b0;
        for (int b = 0; b < NBANK; b++)
            if (is_row_cmd(bank_cmd[CMD_W*b +: CMD_W])) any_row = 1'b1;
    end

    // R1
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (occ == '0) && acc_ready);

    // R3
    a_r3_row_first: assert property (@(posedge clk) disable iff (rst)
        any_row |-> iss_valid && is_row_cmd(iss_cmd));

    // R5
    a_r5_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5
    a_r5_grant_bank: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (grant == (NBANK'(1) << iss_bank)));

    // R6
    a_r6_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> (grant == '0));

    // R7
    a_r7_push_pop: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_ready && iss_valid && is_col_cmd(iss_cmd)) |=> (occ == $past(occ)));

    // R8
    a_r8_full_block: assert property (@(posedge clk) disable iff (rst)
        (occ == OCC_W'(DEPTH)) |-> !acc_ready);

    // R8
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));
endmodule

bind inorder_cmd_arb inorder_cmd_arb_chk #(.NBANK(NBANK), .ID_W(ID_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .bank_cmd(bank_cmd), .iss_valid(iss_valid), .iss_cmd(iss_cmd),
    .iss_bank(iss_bank), .grant(grant), .occ(occ)
);

// File: tb/sim_inorder_cmd_arb.sv
module sim_inorder_cmd_arb;
    localparam int NBANK = 4;
    localparam int ID_W  = 4;
    localparam int DEPTH = 4;

    localparam logic [2:0] NO = 3'd0, AC = 3'd1, PR = 3'd2, RD = 3'd3, WR = 3'd4;

    typedef struct packed {
        logic        av;
        logic [3:0]  aid;
        logic [11:0] cmd;
        logic [15:0] ids;
        logic        ev;
        logic [2:0]  ecmd;
        logic [1:0]  ebank;
        logic [3:0]  eid;
        logic        erdy;
    } vec_t;

    // bank fields are {bank3, bank2, bank1, bank0}
    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        // R2: accept 5, nothing offered
        '{1'b1, 4'd5, {NO,NO,NO,NO}, {4'd0,4'd0,4'd0,4'd0}, 1'b0, NO, 2'd0, 4'd0, 1'b1},
        // R3: ACT bank2 beats RD bank1; accept 6
        '{1'b1, 4'd6, {NO,AC,RD,NO}, {4'd0,4'd6,4'd5,4'd0}, 1'b1, AC, 2'd2, 4'd6, 1'b1},
        // R4: head 5: WR bank3 id5 issued, RD bank0 id6 not
        '{1'b0, 4'd0, {WR,NO,NO,RD}, {4'd5,4'd0,4'd0,4'd6}, 1'b1, WR, 2'd3, 4'd5, 1'b1},
        // R7: head 6 issued while 7 accepted
        '{1'b1, 4'd7, {NO,NO,NO,RD}, {4'd0,4'd0,4'd0,4'd6}, 1'b1, RD, 2'd0, 4'd6, 1'b1},
        // R3: PRE bank1 lowest row, head-match WR bank0 waits
        '{1'b0, 4'd0, {AC,NO,PR,WR}, {4'd1,4'd0,4'd9,4'd7}, 1'b1, PR, 2'd1, 4'd9, 1'b1},
        // R4: two head matches, lowest bank0
        '{1'b0, 4'd0, {NO,RD,NO,WR}, {4'd0,4'd7,4'd0,4'd7}, 1'b1, WR, 2'd0, 4'd7, 1'b1},
        // R6: queue empty, column offered
        '{1'b0, 4'd0, {NO,NO,RD,NO}, {4'd0,4'd0,4'd7,4'd0}, 1'b0, NO, 2'd0, 4'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [3:0]  acc_id = '0;
    logic        acc_ready;
    logic [11:0] bank_cmd = '0;
    logic [15:0] bank_id = '0;
    logic        iss_valid;
    logic [2:0]  iss_cmd;
    logic [1:0]  iss_bank;
    logic [3:0]  iss_id;
    logic [3:0]  grant;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    inorder_cmd_arb #(.NBANK(NBANK), .ID_W(ID_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_id(acc_id),
        .acc_ready(acc_ready), .bank_cmd(bank_cmd), .bank_id(bank_id),
        .iss_valid(iss_valid), .iss_cmd(iss_cmd), .iss_bank(iss_bank),
        .iss_id(iss_id), .grant(grant)
    );

    task automatic check(input string req, input logic ev, input logic [2:0] ec,
                         input logic [1:0] eb, input logic [3:0] ei, input logic er);
        logic [3:0] eg;
        eg = ev ? (4'b1 << eb) : 4'b0;
        checks++;
        if (iss_valid !== ev || iss_cmd !== ec || grant !== eg || acc_ready !== er ||
            (ev && (iss_bank !== eb || iss_id !== ei))) begin
            failures++;
            $display("FAIL %s: got v=%b cmd=%0d bank=%0d id=%0d gnt=%b rdy=%b exp v=%b cmd=%0d bank=%0d id=%0d gnt=%b rdy=%b",
                     req, iss_valid, iss_cmd, iss_bank, iss_id, grant, acc_ready,
                     ev, ec, eb, ei, eg, er);
        end
    endtask

    // drive at negedge, check 2 ns later (outputs are combinational), edge at +5
    task automatic step(input logic av, input logic [3:0] aid,
                        input logic [11:0] c, input logic [15:0] i);
        @(negedge clk);
        acc_valid = av;
        acc_id    = aid;
        bank_cmd  = c;
        bank_id   = i;
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1'b0, 4'd0, '0, '0);
        check("R1 reset idle", 1'b0, NO, 2'd0, 4'd0, 1'b1);
        // R1: column offered right after reset with empty queue
        step(1'b0, 4'd0, {NO,NO,NO,RD}, {4'd0,4'd0,4'd0,4'd0});
        check("R1 no column on empty queue", 1'b0, NO, 2'd0, 4'd0, 1'b1);

        for (int k = 0; k < NV; k++) begin
            step(TBL[k].av, TBL[k].aid, TBL[k].cmd, TBL[k].ids);
            check($sformatf("R2-table row %0d", k), TBL[k].ev, TBL[k].ecmd,
                  TBL[k].ebank, TBL[k].eid, TBL[k].erdy);
        end

        // R8: fill queue with 1,2,3,4
        for (int k = 1; k <= DEPTH; k++) begin
            step(1'b1, 4'(k), '0, '0);
            check("R8 filling", 1'b0, NO, 2'd0, 4'd0, 1'b1);
        end
        step(1'b1, 4'd9, '0, '0);
        check("R8 full blocks accept", 1'b0, NO, 2'd0, 4'd0, 1'b0);
        // R6: non-head column id 2 while head is 1
        step(1'b0, 4'd0, {NO,RD,NO,NO}, {4'd0,4'd2,4'd0,4'd0});
        check("R6 non-head column held", 1'b0, NO, 2'd0, 4'd0, 1'b0);
        // R2: drain in order, offer all ids at once on banks 3..0 reversed
        for (int k = 1; k <= DEPTH; k++) begin
            step(1'b0, 4'd0, {RD,WR,RD,WR}, {4'd1,4'd2,4'd3,4'd4});
            check($sformatf("R2 drain order id %0d", k), 1'b1,
                  (k % 2 == 0) ? WR : RD, 2'(4 - k), 4'(k), (k == 1) ? 1'b0 : 1'b1);
        end
        // R8: id 9 must not have been stored; queue now empty
        step(1'b0, 4'd0, {NO,NO,RD,NO}, {4'd0,4'd0,4'd9,4'd0});
        check("R8 blocked id not stored", 1'b0, NO, 2'd0, 4'd0, 1'b1);
        // R7: push/pop overlap ordering: accept 10,11 then pop 10 with accept 12
        step(1'b1, 4'd10, '0, '0);
        step(1'b1, 4'd11, '0, '0);
        step(1'b1, 4'd12, {NO,NO,NO,WR}, {4'd0,4'd0,4'd0,4'd10});
        check("R7 pop head during accept", 1'b1, WR, 2'd0, 4'd10, 1'b1);
        step(1'b0, 4'd0, {NO,NO,RD,RD}, {4'd0,4'd0,4'd11,4'd12});
        check("R7 next head is older id", 1'b1, RD, 2'd1, 4'd11, 1'b1);
        step(1'b0, 4'd0, {NO,NO,RD,RD}, {4'd0,4'd0,4'd11,4'd12});
        check("R7 pushed id follows", 1'b1, RD, 2'd0, 4'd12, 1'b1);
        // R5: row commands on all banks, only bank0 granted
        step(1'b0, 4'd0, {PR,AC,PR,AC}, {4'd3,4'd2,4'd1,4'd0});
        check("R5 single grant", 1'b1, AC, 2'd0, 4'd0, 1'b1);
        // R1: reset in the middle clears the queue
        step(1'b1, 4'd3, '0, '0);
        @(negedge clk); rst = 1'b1; acc_valid = 1'b0;
        @(negedge clk); rst = 1'b0;
        step(1'b0, 4'd0, {NO,NO,NO,RD}, {4'd0,4'd0,4'd0,4'd3});
        check("R1 reset clears queue", 1'b0, NO, 2'd0, 4'd0, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule